// File: doc/BRIEF.md
# Overmodulation Dwell-Time Scaler

This block is one step of a space-vector modulation pipeline. It takes the two dwell times of the active basic vectors in the current sector and returns corrected dwell times that always fit within one switching period. Times are unsigned Q14 values, where one full switching period is `0x4000`. When the sum of the two times fits inside the period they pass through unchanged. When the sum exceeds the period, the block applies one of two fixes. It either shrinks both times by the same factor, or it snaps the output to a single basic vector that fills the whole period.

One iterative restoring divider is reused for both output divisions. The operands are chosen per case so that every request, including pass-through, runs the same two divisions. The latency is therefore the same for every request and every motor. A mode input turns the snapping behaviour off. A motor tag travels alongside the data so the result can be matched to its axis.

A request is accepted on a clock edge where `start` is high and `busy` is low. The result appears together with a one-cycle `done` pulse.

Top module: `svm_ovm_scaler`

## Requirements
- R1: After reset, `busy`, `done`, `tx_out`, `ty_out` and `tag_out` are all zero.
- R2: If `tx_in + ty_in <= 0x4000`, the outputs equal the inputs, whatever the value of `ovm_en`.
- R3: If `ovm_en` is 1, the sum exceeds `0x4000`, `tx_in >= 0x4000` and `tx_in >= ty_in`, then `tx_out = 0x4000` and `ty_out = 0`. This includes a tie at or above the period and the case `ty_in = 0`.
- R4: If `ovm_en` is 1, the sum exceeds `0x4000`, `ty_in >= 0x4000` and `ty_in > tx_in`, then `tx_out = 0` and `ty_out = 0x4000`. This includes the case `tx_in = 0`.
- R5: If `ovm_en` is 1, the sum exceeds `0x4000` and both inputs are below `0x4000`, then `tx_out = floor(tx_in*16384/(tx_in+ty_in))`, and `ty_out` is formed the same way from `ty_in`.
- R6: If `ovm_en` is 0 and the sum exceeds `0x4000`, the proportional formula of R5 applies for any input magnitudes.
- R7: `done` is a single-cycle pulse. It rises exactly 34 clock edges after the accepting edge in every case. `busy` is high from the accepting edge until the edge where `done` rises.
- R8: A `start` asserted while `busy` is high is ignored, and the running result is not disturbed.
- R9: `tag_out` returns the `tag_in` value captured at acceptance. All three outputs hold their value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted when not busy |
| ovm_en | input | 1 | 1 enables snapping, 0 keeps proportional scaling only |
| tx_in | input | 16 | First adjacent-vector dwell time, Q14, bit 15 zero |
| ty_in | input | 16 | Second adjacent-vector dwell time, Q14, bit 15 zero |
| tag_in | input | 3 | Motor number |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid pulse |
| tx_out | output | 16 | Corrected first dwell time, Q14 |
| ty_out | output | 16 | Corrected second dwell time, Q14 |
| tag_out | output | 3 | Motor number of the result |

## Verification
The assertions assume that both input times stay below `0x8000`. Under that assumption the sum fits the 16-bit divisor, and each dividend is less than four times its divisor. With those bounds, the sum of the two output times can never exceed one period. The stimulus keeps bit 15 clear on every input. It mixes directed corner cases (exact sum of one period, ties, zero partners and the mode switched off) with bounded pseudo-random times. It also pulses `start` in the middle of a run to exercise R8.

// File: rtl/svm_ovm_pkg.sv
// Shared types for the overmodulation dwell-time scaler.
package svm_ovm_pkg;
    // Correction chosen for a request.
    typedef enum logic [1:0] {
        OVM_PASS   = 2'd0,
        OVM_SNAP_X = 2'd1,
        OVM_SNAP_Y = 2'd2,
        OVM_SCALE  = 2'd3
    } ovm_case_e;
endpackage

// File: rtl/svm_ovm_sel.sv
// Case selector: classifies the dwell-time pair and picks both division operand pairs.
// Assumes bit DW-1 of each time is zero, so the sum fits DW bits.
module svm_ovm_sel
    import svm_ovm_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input  logic [DW-1:0] tx,
    input  logic [DW-1:0] ty,
    input  logic          ovm_en,
    output logic [DW-1:0] num_a,
    output logic [DW-1:0] den_a,
    output logic [DW-1:0] num_b,
    output logic [DW-1:0] den_b,
    output ovm_case_e     sel
);
    localparam logic [DW:0]   ONE_W = (DW+1)'(1) << FRAC;
    localparam logic [DW-1:0] ONE   = DW'(1) << FRAC;

    logic [DW:0] sum;

    // Sum of the two dwell times, one bit wider than the inputs.
    always_comb sum = {1'b0, tx} + {1'b0, ty};

    // Classify the pair; on a tie the first vector wins.
    always_comb begin
        if (sum <= ONE_W)
            sel = OVM_PASS;
        else if (!ovm_en)
            sel = OVM_SCALE;
        else if (tx >= ONE && tx >= ty)
            sel = OVM_SNAP_X;
        else if (ty >= ONE)
            sel = OVM_SNAP_Y;
        else
            sel = OVM_SCALE;
    end

    // Operand table; every case feeds two real divisions.
    always_comb begin
        unique case (sel)
            OVM_PASS: begin
                num_a = tx;  den_a = ONE;
                num_b = ty;  den_b = ONE;
            end
            OVM_SNAP_X: begin
                num_a = ONE; den_a = ONE;
                num_b = '0;  den_b = ty;
            end
            OVM_SNAP_Y: begin
                num_a = '0;  den_a = tx;
                num_b = ONE; den_b = ONE;
            end
            default: begin
                num_a = tx;  den_a = sum[DW-1:0];
                num_b = ty;  den_b = sum[DW-1:0];
            end
        endcase
    end
endmodule

// File: rtl/svm_ovm_div.sv
// Restoring divider: one quotient bit per cycle, QW bits, MSB first.
// Quotient bit k weighs 2^(k-FRAC). Assumes num < 4*den; a zero divisor gives zero.
module svm_ovm_div #(
    parameter int DW = 16,
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [QW-1:0] quo
);
    localparam int RW = DW + 2;
    localparam int CW = $clog2(QW + 1);

    logic [RW-1:0] rem;
    logic [DW-1:0] dvs;
    logic [CW-1:0] left;
    logic [RW-1:0] dvs2;
    logic          qbit;
    logic [RW-1:0] rem_nx;

    // Trial subtraction of twice the divisor against the running remainder.
    always_comb begin
        dvs2   = {1'b0, dvs, 1'b0};
        qbit   = (dvs != '0) && (rem >= dvs2);
        rem_nx = qbit ? (rem - dvs2) : rem;
    end

    // Load operands, then step once per cycle until all bits are produced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            dvs  <= '0;
            left <= '0;
            quo  <= '0;
        end else if (ld) begin
            rem  <= RW'(num);
            dvs  <= den;
            left <= CW'(QW);
            quo  <= '0;
        end else if (left != '0) begin
            rem  <= {rem_nx[RW-2:0], 1'b0};
            quo  <= {quo[QW-2:0], qbit};
            left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/svm_ovm_ctrl.sv
// Sequencer: accepts one request, runs division A then division B, then finishes.
// Fixed schedule of 2*QW+2 edges from acceptance to done.
module svm_ovm_ctrl #(
    parameter int QW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic ld_a,
    output logic ld_b,
    output logic fin
);
    localparam int LAST = 2 * QW + 1;
    localparam int CW   = $clog2(LAST + 1);

    logic [CW-1:0] cnt;

    // Phase strobes decoded from the step counter.
    always_comb begin
        ld_a = start && !busy;
        ld_b = busy && (cnt == CW'(QW));
        fin  = busy && (cnt == CW'(LAST));
    end

    // Busy flag and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (ld_a) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (fin) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/svm_ovm_scaler.sv
// Top: overmodulation dwell-time scaler with constant latency.
// Inputs are Q14 with one period = 1<<FRAC; bit DW-1 of each input must be zero.
module svm_ovm_scaler
    import svm_ovm_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 14,
    parameter int TW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ovm_en,
    input  logic [DW-1:0] tx_in,
    input  logic [DW-1:0] ty_in,
    input  logic [TW-1:0] tag_in,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] tx_out,
    output logic [DW-1:0] ty_out,
    output logic [TW-1:0] tag_out
);
    localparam int QW = DW;

    logic [DW-1:0] num_a, den_a, num_b, den_b;
    logic [DW-1:0] nb_q, db_q, qa_q;
    logic [DW-1:0] div_num, div_den;
    logic [QW-1:0] quo;
    logic [TW-1:0] tag_q;
    logic          ld_a, ld_b, fin;
    ovm_case_e     sel;

    svm_ovm_sel #(.DW(DW), .FRAC(FRAC)) u_sel (
        .tx(tx_in), .ty(ty_in), .ovm_en(ovm_en),
        .num_a(num_a), .den_a(den_a), .num_b(num_b), .den_b(den_b),
        .sel(sel)
    );

    svm_ovm_ctrl #(.QW(QW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .ld_a(ld_a), .ld_b(ld_b), .fin(fin)
    );

    // Divider operands: live pair A at acceptance, stored pair B later.
    always_comb begin
        div_num = ld_a ? num_a : nb_q;
        div_den = ld_a ? den_a : db_q;
    end

    svm_ovm_div #(.DW(DW), .QW(QW)) u_div (
        .clk(clk), .rst_n(rst_n), .ld(ld_a || ld_b),
        .num(div_num), .den(div_den), .quo(quo)
    );

    // Request capture, first-quotient capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nb_q    <= '0;
            db_q    <= '0;
            tag_q   <= '0;
            qa_q    <= '0;
            tx_out  <= '0;
            ty_out  <= '0;
            tag_out <= '0;
            done    <= 1'b0;
        end else begin
            done <= fin;
            if (ld_a) begin
                nb_q  <= num_b;
                db_q  <= den_b;
                tag_q <= tag_in;
            end
            if (ld_b)
                qa_q <= quo[DW-1:0];
            if (fin) begin
                tx_out  <= qa_q;
                ty_out  <= quo[DW-1:0];
                tag_out <= tag_q;
            end
        end
    end
endmodule

// File: rtl/svm_ovm_scaler_chk.sv
// Protocol and range checker for svm_ovm_scaler, attached by bind.
// Assumes inputs keep bit DW-1 clear.
module svm_ovm_scaler_chk #(
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] tx_out,
    input logic [DW-1:0] ty_out
);
    localparam int LAT = 2 * DW + 2;
    localparam int CW  = $clog2(LAT + 2);

    logic [CW-1:0] age;

    // Edges elapsed since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (start && !busy)
            age <= '0;
        else if (busy)
            age <= age + 1'b1;
    end

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (age == CW'(LAT)));
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && age < CW'(LAT - 1)) |=> busy);
    a_r9_hold_x: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(tx_out));
    a_r9_hold_y: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ty_out));
    a_r5_within_period: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({1'b0, tx_out} + {1'b0, ty_out}) <= ((DW+1)'(1) << FRAC));
endmodule

bind svm_ovm_scaler svm_ovm_scaler_chk #(.DW(DW), .FRAC(FRAC)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .tx_out(tx_out), .ty_out(ty_out)
);

// File: tb/svm_ovm_scaler_tb.sv
// Bench: behavioural cycle model compared on every clock, plus directed and random requests.
module svm_ovm_scaler_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ovm_en = 1'b1;
    logic [15:0] tx_in = '0;
    logic [15:0] ty_in = '0;
    logic [2:0]  tag_in = '0;
    logic        busy, done;
    logic [15:0] tx_out, ty_out;
    logic [2:0]  tag_out;

    int checks = 0;
    int errors = 0;
    int age = -1;
    int e_x = 0, e_y = 0, e_t = 0;
    int p_x, p_y, p_t;
    string p_req = "R2";
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    svm_ovm_scaler u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ovm_en(ovm_en),
        .tx_in(tx_in), .ty_in(ty_in), .tag_in(tag_in),
        .busy(busy), .done(done), .tx_out(tx_out), .ty_out(ty_out),
        .tag_out(tag_out)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int qdiv(int n, int d);
        if (d == 0) return 0;
        return (n * 16384) / d;
    endfunction

    // Reference model: accept on a free edge, count edges to the result.
    always @(posedge clk) begin
        if (!rst_n) begin
            age = -1;
        end else if (age >= 0) begin
            age = age + 1;
        end else if (start) begin
            int s;
            age = 0;
            p_t = int'(tag_in);
            s = int'(tx_in) + int'(ty_in);
            if (s <= 16384) begin
                p_x = int'(tx_in); p_y = int'(ty_in); p_req = "R2";
            end else if (ovm_en && tx_in >= 16384 && tx_in >= ty_in) begin
                p_x = 16384; p_y = 0; p_req = "R3";
            end else if (ovm_en && ty_in >= 16384) begin
                p_x = 0; p_y = 16384; p_req = "R4";
            end else begin
                p_x = qdiv(tx_in, s); p_y = qdiv(ty_in, s);
                p_req = ovm_en ? "R5" : "R6";
            end
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !finished) begin
            chk("R7 done", int'(done), int'(age == 34));
            chk("R7 busy", int'(busy), int'(age >= 0 && age < 34));
            if (age == 34) begin
                e_x = p_x; e_y = p_y; e_t = p_t;
                chk(p_req, int'(tx_out), e_x);
                chk(p_req, int'(ty_out), e_y);
                age = -1;
            end else begin
                chk("R9 hold x", int'(tx_out), e_x);
                chk("R9 hold y", int'(ty_out), e_y);
            end
            chk("R9 tag", int'(tag_out), e_t);
        end
        if (cyc > 150000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic req(int x, int y, bit m, int t);
        @(negedge clk);
        while (busy) @(negedge clk);
        tx_in = 16'(x); ty_in = 16'(y); ovm_en = m; tag_in = 3'(t);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || age >= 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values at the ports.
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 tx", int'(tx_out), 0);
        chk("R1 ty", int'(ty_out), 0);
        chk("R1 tag", int'(tag_out), 0);
        rst_n = 1'b1;

        req(16'h1000, 16'h2000, 1, 1);    // R2 linear
        req(16'h2000, 16'h2000, 1, 2);    // R2 exact period
        req(16'h2000, 16'h2000, 0, 3);    // R2 mode off
        req(16'h5000, 16'h0800, 1, 4);    // R3 snap x
        req(16'h4800, 16'h0000, 1, 5);    // R3 zero divisor
        req(16'h4000, 16'h4000, 1, 6);    // R3 tie
        req(16'h0000, 16'h6000, 1, 7);    // R4 zero divisor
        req(16'h1000, 16'h4400, 1, 0);    // R4 snap y
        req(16'h3000, 16'h2000, 1, 1);    // R5 scale
        req(16'h3FFF, 16'h3FFF, 1, 2);    // R5 near corner
        req(16'h6000, 16'h2000, 0, 3);    // R6 mode off large
        req(16'h7FFF, 16'h7FFF, 0, 4);    // R6 maximum sum
        wait_idle();
        chk("R5 scale x", int'(qdiv(16'h3000, 16'h5000)), 9830);

        // R8: start pulsed mid-run with different data.
        req(16'h3000, 16'h2000, 1, 5);
        repeat (10) @(negedge clk);
        tx_in = 16'h5000; ty_in = 16'h0000; tag_in = 3'd6; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        chk("R8 x", int'(tx_out), 9830);
        chk("R8 y", int'(ty_out), 6553);
        chk("R8 tag", int'(tag_out), 5);

        for (int i = 0; i < 60; i++)
            req(int'($urandom % 32768), int'($urandom % 32768),
                bit'($urandom % 2), int'($urandom % 8));
        for (int i = 0; i < 30; i++)
            req(int'($urandom % 12000), int'($urandom % 12000), 1'b1, i % 8);
        wait_idle();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule